// File: doc/BRIEF.md
# Asymmetric SCL Phase Generator

This block derives the serial clock of a two-wire bus master from a fast input clock. The low and the high part of each bus clock period are programmed independently through one divider word. Each part is counted in units of a fixed prescale (eight input clocks by default), so slow standard-mode periods and fast periods up to 400 kHz come out of the same logic. Software writes raw divider values; nothing in the block converts a target frequency.

Besides the clock itself, the block gives the byte engine two single-cycle strobes. The first marks the middle of every low part, where the data line may change, so data hold equals half the low time. The second marks the middle of every high part, where the data line is sampled. The generator runs only while the master requests bus activity. When it is stopped, the clock line rests high and both strobes are quiet.

A divider word written while the generator runs never stretches or cuts the part in progress. The new low or high value is picked up at the next boundary between parts.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is asserted, scl_o is 1 and sda_chg_o and smp_o are 0.
- R2: The first clock edge that samples run_i at 1 while the generator is idle starts a low part: scl_o is 0 from the following cycle, for exactly (lo+1)*PRE input clocks.
- R3: Each high part holds scl_o at 1 for exactly (hi+1)*PRE input clocks, and the low and high parts then alternate for as long as run_i stays 1.
- R4: In div_cfg_i, bits [DIV_W-1:0] carry the low divider lo, and bits [2*DIV_W-1:DIV_W] carry the high divider hi.
- R5: sda_chg_o is a one-cycle pulse, once per low part, in the cycle at zero-based offset (lo+1)*PRE/2 from the first low cycle. It is never 1 while scl_o is 1.
- R6: smp_o is a one-cycle pulse, once per high part, at zero-based offset (hi+1)*PRE/2 from the first high cycle. It is never 1 while scl_o is 0.
- R7: A change of div_cfg_i does not alter the length of the part in progress. Each part takes its divider from the value present at the clock edge that ends the previous part, or at the start edge for the first low part.
- R8: The largest field value, 2^DIV_W-1, gives a part of 2^DIV_W*PRE input clocks with no counter wrap.
- R9: A clock edge that samples run_i at 0 makes scl_o 1 and both strobes 0 from the next cycle on. Raising run_i again starts over with a fresh low part.
- R10: A field value of 0 gives a part of exactly PRE input clocks, with its strobe at offset PRE/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Bus activity request from the master; 1 runs the generator |
| div_cfg_i | input | 2*DIV_W | Divider word: high divider in the upper half, low divider in the lower half |
| scl_o | output | 1 | Serial clock level |
| sda_chg_o | output | 1 | One-cycle strobe at the middle of each low part |
| smp_o | output | 1 | One-cycle strobe at the middle of each high part |

## Verification
The assertions check on every cycle that each strobe only appears in its own clock level and lasts one cycle. They also check that stopping makes the outputs idle on the next cycle, that a low part never collapses to a single cycle, and that the divider in use stays frozen inside a part. Exact part lengths, strobe offsets, the field order in the divider word, and the hand-over of a divider changed in mid-part can only be shown by the bench scenarios. These scenarios compare every cycle against a cycle model driven by random and directed divider values, and include a second, narrow instance that reaches the largest field value.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
   parameter int unsigned PRE = 8,
   localparam int unsigned PW = (PRE > 1) ? $clog2(PRE) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   output logic [PW-1:0] cnt_o,
   output logic          tick_o
);
   import scl_phase_pkg::*;

   localparam logic [PW-1:0] LAST = PW'(PRE - 1);

   logic [PW-1:0] cnt_q;

   generate
      if (is_pow2(PRE)) begin : g_wrap
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (!en_i) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else begin : g_cmp
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (!en_i) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign cnt_o  = cnt_q;
   assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
   parameter int unsigned DIV_W = 16
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        run_i,
   input  logic                        tick_i,
   input  logic [DIV_W-1:0]            lo_div_i,
   input  logic [DIV_W-1:0]            hi_div_i,
   output logic                        active_o,
   output scl_phase_pkg::phase_e       phase_o,
   output logic [DIV_W-1:0]            unit_o,
   output logic [DIV_W-1:0]            div_o
);
   import scl_phase_pkg::*;

   logic             active_q;
   phase_e           phase_q;
   logic [DIV_W-1:0] unit_q;
   logic [DIV_W-1:0] div_q;
   logic             last_unit;

   assign last_unit = (unit_q == div_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         phase_q  <= PH_LOW;
         unit_q   <= '0;
         div_q    <= '0;
      end else if (!run_i) begin
         active_q <= 1'b0;
         phase_q  <= PH_LOW;
         unit_q   <= '0;
      end else if (!active_q) begin
         active_q <= 1'b1;
         phase_q  <= PH_LOW;
         unit_q   <= '0;
         div_q    <= lo_div_i;
      end else if (tick_i) begin
         if (last_unit) begin
            unit_q <= '0;
            if (phase_q == PH_LOW) begin
               phase_q <= PH_HIGH;
               div_q   <= hi_div_i;
            end else begin
               phase_q <= PH_LOW;
               div_q   <= lo_div_i;
            end
         end else begin
            unit_q <= unit_q + 1'b1;
         end
      end
   end

   assign active_o = active_q;
   assign phase_o  = phase_q;
   assign unit_o   = unit_q;
   assign div_o    = div_q;

endmodule

// File: rtl/scl_strobe_dec.sv
module scl_strobe_dec #(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned PRE   = 8,
   localparam int unsigned PW   = (PRE > 1) ? $clog2(PRE) : 1
) (
   input  logic                  active_i,
   input  scl_phase_pkg::phase_e phase_i,
   input  logic [DIV_W-1:0]      unit_i,
   input  logic [PW-1:0]         pre_i,
   input  logic [DIV_W-1:0]      div_i,
   output logic                  scl_o,
   output logic                  sda_chg_o,
   output logic                  smp_o
);
   import scl_phase_pkg::*;

   localparam logic [PW-1:0] PRE_HALF = PW'(PRE / 2);

   logic [DIV_W:0]  half_unit;
   logic [PW-1:0]   half_pre;
   logic            at_mid;

   // Middle of (div+1)*PRE clocks: an even unit count splits on a unit
   // boundary, an odd one splits in the middle of a prescale unit.
   always_comb begin
      half_unit = ({1'b0, div_i} + 1'b1) >> 1;
      half_pre  = div_i[0] ? '0 : PRE_HALF;
      at_mid    = ({1'b0, unit_i} == half_unit) && (pre_i == half_pre);
   end

   assign scl_o     = !active_i || (phase_i == PH_HIGH);
   assign sda_chg_o = active_i && (phase_i == PH_LOW)  && at_mid;
   assign smp_o     = active_i && (phase_i == PH_HIGH) && at_mid;

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned PRE   = 8,
   localparam int unsigned CFG_W = 2 * DIV_W,
   localparam int unsigned PW    = (PRE > 1) ? $clog2(PRE) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CFG_W-1:0] div_cfg_i,
   output logic             scl_o,
   output logic             sda_chg_o,
   output logic             smp_o
);
   import scl_phase_pkg::*;

   generate
      if (PRE < 2 || (PRE % 2) != 0) begin : g_bad_pre
         $error("scl_phase_gen: PRE must be even and at least 2");
      end
      if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div_w
         $error("scl_phase_gen: DIV_W must be in 1..24");
      end
   endgenerate

   logic [DIV_W-1:0] lo_div;
   logic [DIV_W-1:0] hi_div;
   logic             active;
   phase_e           phase;
   logic [DIV_W-1:0] unit;
   logic [DIV_W-1:0] div_cur;
   logic [PW-1:0]    pre_cnt;
   logic             pre_tick;

   assign lo_div = div_cfg_i[DIV_W-1:0];
   assign hi_div = div_cfg_i[CFG_W-1:DIV_W];

   scl_prescale #(
      .PRE (PRE)
   ) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (active && run_i),
      .cnt_o  (pre_cnt),
      .tick_o (pre_tick)
   );

   scl_phase_ctr #(
      .DIV_W (DIV_W)
   ) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_i),
      .tick_i   (pre_tick),
      .lo_div_i (lo_div),
      .hi_div_i (hi_div),
      .active_o (active),
      .phase_o  (phase),
      .unit_o   (unit),
      .div_o    (div_cur)
   );

   scl_strobe_dec #(
      .DIV_W (DIV_W),
      .PRE   (PRE)
   ) u_dec (
      .active_i  (active),
      .phase_i   (phase),
      .unit_i    (unit),
      .pre_i     (pre_cnt),
      .div_i     (div_cur),
      .scl_o     (scl_o),
      .sda_chg_o (sda_chg_o),
      .smp_o     (smp_o)
   );

endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             run_i,
   input logic             scl_o,
   input logic             sda_chg_o,
   input logic             smp_o,
   input logic             active,
   input logic [DIV_W-1:0] div_cur
);

   p_reset_idle_r1: assert property (@(posedge clk_i)
      !rst_ni |-> (scl_o && !sda_chg_o && !smp_o));

   p_low_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(scl_o) && run_i) |=> !scl_o);

   p_sda_in_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sda_chg_o |-> !scl_o);

   p_sda_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sda_chg_o |=> !sda_chg_o);

   p_smp_in_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_o |-> scl_o);

   p_smp_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_o |=> !smp_o);

   p_hold_div_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && $past(active) && (scl_o == $past(scl_o))) |-> $stable(div_cur));

   p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (scl_o && !sda_chg_o && !smp_o));

endmodule

bind scl_phase_gen scl_phase_gen_chk #(
   .DIV_W (DIV_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .run_i     (run_i),
   .scl_o     (scl_o),
   .sda_chg_o (sda_chg_o),
   .smp_o     (smp_o),
   .active    (active),
   .div_cur   (div_cur)
);

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int DIV_W = 16;
   localparam int PRE   = 8;
   localparam int SW    = 4;
   localparam int SPRE  = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              run;
   logic [2*DIV_W-1:0] cfg;
   logic              scl, sda_chg, smp;
   logic              run_s;
   logic [2*SW-1:0]   cfg_s;
   logic              scl_s, sda_s, smp_s;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // cycle model state
   bit m_act;
   bit m_ph;
   int m_pos;
   int m_len;
   int errs;
   string first_err;

   always #2.5 clk = ~clk;

   scl_phase_gen #(.DIV_W(DIV_W), .PRE(PRE)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .run_i(run), .div_cfg_i(cfg),
      .scl_o(scl), .sda_chg_o(sda_chg), .smp_o(smp));

   scl_phase_gen #(.DIV_W(SW), .PRE(SPRE)) u_small (
      .clk_i(clk), .rst_ni(rst_n), .run_i(run_s), .div_cfg_i(cfg_s),
      .scl_o(scl_s), .sda_chg_o(sda_s), .smp_o(smp_s));

   function automatic int part_len(input int d);
      return (d + 1) * PRE;
   endfunction

   function automatic logic [2*DIV_W-1:0] mk_cfg(input int lo, input int hi);
      return {hi[DIV_W-1:0], lo[DIV_W-1:0]};   // R4: high upper, low lower
   endfunction

   task automatic check(input bit ok, input string req, input string msg);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s", req, msg);
      end
   endtask

   task automatic model_advance(input bit r, input logic [2*DIV_W-1:0] c);
      if (!r) begin
         m_act = 0; m_ph = 0; m_pos = 0;
      end else if (!m_act) begin
         m_act = 1; m_ph = 0; m_pos = 0;
         m_len = part_len(int'(c[DIV_W-1:0]));
      end else if (m_pos == m_len - 1) begin
         m_pos = 0;
         m_len = m_ph ? part_len(int'(c[DIV_W-1:0]))
                      : part_len(int'(c[2*DIV_W-1:DIV_W]));
         m_ph  = !m_ph;
      end else begin
         m_pos++;
      end
   endtask

   // One cycle: compare at the falling edge, then apply new inputs.
   task automatic tick(input bit r, input logic [2*DIV_W-1:0] c, input int idx);
      logic e_scl, e_sda, e_smp;
      @(negedge clk);
      e_scl = !m_act || m_ph;
      e_sda = m_act && !m_ph && (m_pos == m_len / 2);
      e_smp = m_act &&  m_ph && (m_pos == m_len / 2);
      if (scl !== e_scl || sda_chg !== e_sda || smp !== e_smp) begin
         if (errs == 0)
            first_err = $sformatf("cycle %0d actual scl/sda/smp=%b%b%b expected %b%b%b",
                                  idx, scl, sda_chg, smp, e_scl, e_sda, e_smp);
         errs++;
      end
      run = r;
      cfg = c;
      model_advance(r, c);
   endtask

   task automatic scenario(input string req, input int n, input int lo, input int hi,
                           input int chg_at, input int lo2, input int hi2,
                           input int drop_at, input int drop_len);
      errs = 0;
      first_err = "";
      for (int i = 0; i < n; i++) begin
         bit r;
         r = !((i >= drop_at) && (i < drop_at + drop_len)) && (i < n - 4);
         tick(r, (i >= chg_at) ? mk_cfg(lo2, hi2) : mk_cfg(lo, hi), i);
      end
      check(errs == 0, req, $sformatf("lo=%0d hi=%0d: %0d mismatches, first %s",
                                      lo, hi, errs, first_err));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int seed_val;
      int lo, hi, n, chg, drop;
      seed_val = $urandom(32'd2718);
      rst_n = 1'b0;
      run   = 1'b0;
      cfg   = '0;
      run_s = 1'b0;
      cfg_s = '0;
      m_act = 0; m_ph = 0; m_pos = 0; m_len = PRE;

      // R1: idle levels during reset
      repeat (3) @(negedge clk);
      check(scl === 1'b1 && sda_chg === 1'b0 && smp === 1'b0, "R1",
            $sformatf("actual %b%b%b expected 100", scl, sda_chg, smp));
      check(scl_s === 1'b1 && sda_s === 1'b0 && smp_s === 1'b0, "R1",
            $sformatf("small actual %b%b%b expected 100", scl_s, sda_s, smp_s));
      rst_n = 1'b1;

      // R2 R3 R5 R6: basic symmetric run
      scenario("R2 R3 R5 R6", 6 * part_len(3), 3, 3, 1 << 30, 0, 0, 1 << 30, 0);
      // R4: unequal fields show the field order
      scenario("R4", 4 * (part_len(1) + part_len(6)), 1, 6, 1 << 30, 0, 0, 1 << 30, 0);
      // R10: both fields zero
      scenario("R10", 10 * PRE, 0, 0, 1 << 30, 0, 0, 1 << 30, 0);
      // R5 R6: odd unit counts split inside a prescale unit
      scenario("R5 R6", 4 * (part_len(2) + part_len(4)), 2, 4, 1 << 30, 0, 0, 1 << 30, 0);
      // R7: change in the middle of the first low part
      scenario("R7", 6 * part_len(5), 3, 3, 5, 1, 5, 1 << 30, 0);
      // R7: change in the middle of a high part
      scenario("R7", 6 * part_len(5), 2, 4, part_len(2) + 7, 5, 0, 1 << 30, 0);
      // R9: stop in mid-part, then restart
      scenario("R9", 8 * part_len(3), 3, 2, 1 << 30, 0, 0, part_len(3) + 5, 3);
      // R9: stop for one cycle right at start
      scenario("R9", 5 * part_len(2), 2, 2, 1 << 30, 0, 0, 1, 1);

      // random mixes
      for (int k = 0; k < 16; k++) begin
         lo   = int'($urandom_range(0, 15));
         hi   = int'($urandom_range(0, 15));
         n    = 3 * (part_len(lo) + part_len(hi)) + 6;
         chg  = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, n - 1)) : (1 << 30);
         drop = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, n - 1)) : (1 << 30);
         scenario("R2 R3 R5 R6 R7 R9", n, lo, hi, chg,
                  int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                  drop, int'($urandom_range(1, 4)));
      end

      // R8: largest field value on the narrow instance, 2^SW*SPRE clocks
      begin
         int low_cnt, high_cnt;
         int exp_len;
         exp_len = (1 << SW) * SPRE;
         @(negedge clk);
         cfg_s = '1;
         run_s = 1'b1;
         @(negedge clk);
         low_cnt = 0;
         while (scl_s === 1'b0 && low_cnt < 4 * exp_len) begin
            low_cnt++;
            @(negedge clk);
         end
         high_cnt = 0;
         while (scl_s === 1'b1 && high_cnt < 4 * exp_len) begin
            high_cnt++;
            @(negedge clk);
         end
         check(low_cnt == exp_len, "R8",
               $sformatf("low part actual %0d expected %0d", low_cnt, exp_len));
         check(high_cnt == exp_len, "R8",
               $sformatf("high part actual %0d expected %0d", high_cnt, exp_len));
         run_s = 1'b0;
         @(negedge clk);
         @(negedge clk);
         check(scl_s === 1'b1 && sda_s === 1'b0 && smp_s === 1'b0, "R9",
               $sformatf("small stop actual %b%b%b expected 100", scl_s, sda_s, smp_s));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule